// File: doc/BRIEF.md
# Write-Only Serial Control Register Port

This block is a serial slave. A host microcontroller uses it to load a small bank of 8-bit control registers over three wires: an active-low select, a serial clock and a data line. Every wire is an input, so the host cannot read anything back. The block samples the three wires with its own faster system clock. It finds the rising edges of the serial clock in that clock domain and shifts data in MSB first.

A frame opens when select goes low. It starts with a byte made of a 7-bit device identifier and a direction flag. Next comes a pointer byte, and after it one or more data bytes. The top bit of the pointer byte picks one of two modes:

- **Fixed target:** every data byte goes to the same register.
- **Sequential:** each data byte goes to the next register up.

The register contents appear as one flat parallel output bus, with register *i* on bits `[8*i+7 : 8*i]`.

Top module: `spi_wr_regport`

## Requirements
- R1: Data is taken from `sdi_in` at rising edges of `sclk_in` while `cs_n_in` is low, most significant bit first. For example, data byte 0x01 stores 0x01, not 0x80.
- R2: The first seven bits of a frame must equal the device identifier 7'b0010000. If they do not, the rest of the frame writes nothing.
- R3: The eighth bit is the direction flag. A frame with the flag at 1 (read) writes nothing.
- R4: After a valid header, the second byte sets the pointer: bits 6:0 give the register index. The third byte is stored into the register the pointer selects.
- R5: Bit 7 of the pointer byte controls further data bytes in the frame:
  - At 0, they all overwrite the same register.
  - At 1, the pointer rises by one after each stored byte.
- R6: Raising `cs_n_in` ends the frame at any bit. A byte that is only partly shifted in is discarded, and the next low phase of select starts a fresh header.
- R7: While `rst_n` is low, every register reads 0x00. After reset, a register keeps its value until a new write reaches it.
- R8: A data byte aimed at a pointer value of 16 or more changes no register. A sequential write that passes index 15 does not wrap around to index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial wires |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_in | input | 1 | Active-low frame select from the host |
| sclk_in | input | 1 | Serial bit clock from the host; data is taken on its rising edge |
| sdi_in | input | 1 | Serial data from the host, MSB first |
| reg_q | output | NUM_REGS*8 | All registers, register i on bits [8*i+7:8*i] |

## Verification
Corrupted internal state shows up on `reg_q`. A wrong bit counter or header decision leaves the wrong register changed, or no register changed, once the data byte is complete. A wrong pointer or increment flag puts a byte into a neighbouring register. Either error becomes visible on the port a few system clocks after the last rising edge of the serial clock in that byte. A corrupted abort path leaves a stale bit in the shifter, which shifts every field of the next frame by that bit, so the next frame lands in the wrong place. Out-of-range and read frames are checked against registers that must stay at their earlier values.

// File: rtl/spi_wr_pkg.sv
// Shared definitions for the serial write-only register port.
// Assumes byte-wide serial fields and registers.
package spi_wr_pkg;

    localparam int BYTE_W = 8;

    // Position inside a frame: header byte, pointer byte, data bytes,
    // or discarding the rest after a rejected header.
    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_PTR  = 2'd1,
        ST_DATA = 2'd2,
        ST_SKIP = 2'd3
    } frm_state_t;

endpackage

// File: rtl/spi_wr_sync.sv
// Multi-stage synchroniser that brings one asynchronous wire into the
// system clock domain. Assumes the wire changes far slower than clk.
module spi_wr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the raw wire through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_wr_frame.sv
// Frame decoder. Detects serial clock rising edges from synchronised
// inputs, assembles bytes MSB first, checks the header, keeps the
// register pointer, and issues one write pulse per accepted data byte.
// Assumes cs_n_s, sclk_s and sdi_s went through equal synchroniser depth.
module spi_wr_frame
    import spi_wr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b0010000,
    parameter int         PTR_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_s,
    input  logic             sclk_s,
    input  logic             sdi_s,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);

    localparam int CNT_W = $clog2(BYTE_W);

    frm_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] byte_nxt;
    logic [PTR_W-1:0]  ptr;
    logic              inc_en;
    logic              sclk_q;
    logic              sclk_rise;
    logic              byte_done;

    // Rising edge of the serial clock, seen in the system clock domain.
    assign sclk_rise = sclk_s & ~sclk_q;
    // Byte value including the bit arriving on this edge.
    assign byte_nxt  = {shreg[BYTE_W-2:0], sdi_s};
    // Last bit of a byte arrives on this edge.
    assign byte_done = sclk_rise && (bit_cnt == CNT_W'(BYTE_W - 1));

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    // Shift register and bit counter; cleared whenever select is high.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (sclk_rise && state != ST_SKIP) begin
            shreg   <= byte_nxt;
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Frame sequencing: header check, pointer load, data handling.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            state <= ST_HDR;
        end else if (byte_done) begin
            case (state)
                ST_HDR:  state <= (byte_nxt[7:1] == DEV_ADDR && !byte_nxt[0])
                                  ? ST_PTR : ST_SKIP;
                ST_PTR:  state <= ST_DATA;
                default: state <= state;
            endcase
        end
    end

    // Pointer and increment flag, loaded from the pointer byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            inc_en <= 1'b0;
        end else if (!cs_n_s && byte_done) begin
            if (state == ST_PTR) begin
                ptr    <= byte_nxt[PTR_W-1:0];
                inc_en <= byte_nxt[BYTE_W-1];
            end else if (state == ST_DATA && inc_en) begin
                ptr    <= ptr + 1'b1;
            end
        end
    end

    // Registered write request for each complete data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= !cs_n_s && byte_done && state == ST_DATA;
            if (!cs_n_s && byte_done && state == ST_DATA) begin
                wr_addr <= ptr;
                wr_data <= byte_nxt;
            end
        end
    end

endmodule

// File: rtl/spi_wr_regbank.sv
// Bank of byte registers written by index. Indices outside the bank
// are dropped. Assumes at most one write per clock.
module spi_wr_regbank
    import spi_wr_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int ADDR_W   = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [BYTE_W-1:0]          wr_data,
    output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [BYTE_W-1:0] r;

        // Load this register when the write index matches it.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   r <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i))      r <= wr_data;
        end

        assign regs_flat[i*BYTE_W +: BYTE_W] = r;
    end

endmodule

// File: rtl/spi_wr_regport.sv
// Top of the write-only serial register port. Synchronises the three
// host wires, decodes frames and holds the register bank.
// Assumes the host serial clock is several times slower than clk.
module spi_wr_regport
    import spi_wr_pkg::*;
#(
    parameter int         NUM_REGS    = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'b0010000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n_in,
    input  logic                       sclk_in,
    input  logic                       sdi_in,
    output logic [NUM_REGS*BYTE_W-1:0] reg_q
);

    localparam int PTR_W = BYTE_W - 1;

    logic              cs_s;
    logic              sclk_s;
    logic              sdi_s;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_addr;
    logic [BYTE_W-1:0] wr_data;

    spi_wr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .d(cs_n_in), .q(cs_s)
    );
    spi_wr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .d(sclk_in), .q(sclk_s)
    );
    spi_wr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
        .clk(clk), .rst_n(rst_n), .d(sdi_in), .q(sdi_s)
    );

    spi_wr_frame #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .cs_n_s(cs_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    spi_wr_regbank #(.NUM_REGS(NUM_REGS), .ADDR_W(PTR_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .regs_flat(reg_q)
    );

endmodule

// File: rtl/spi_wr_regport_chk.sv
// Property checker for spi_wr_regport, attached by bind. Observes the
// write request between decoder and bank, and the register outputs.
module spi_wr_regport_chk #(
    parameter int NUM_REGS = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs_s,
    input logic                  wr_en,
    input logic [6:0]            wr_addr,
    input logic [7:0]            wr_data,
    input logic [NUM_REGS*8-1:0] reg_q
);

    AST_NO_WR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reg_q)); // R7

    AST_OOR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= 7'(NUM_REGS)) |=> $stable(reg_q)); // R8

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr < 7'(NUM_REGS)) |=>
            reg_q[$past(wr_addr)*8 +: 8] == $past(wr_data)); // R4

    AST_IDLE_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !wr_en); // R6

    AST_SINGLE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R1

endmodule

bind spi_wr_regport spi_wr_regport_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .reg_q(reg_q)
);

// File: tb/sim_spi_wr_regport.sv
// Self-checking bench for spi_wr_regport: vector table, then directed tests.
module sim_spi_wr_regport;

    localparam int NREG = 16;
    localparam int HALF = 6;

    typedef struct packed {
        logic [39:0] bytes;   // frame bytes, first byte in bits 39:32
        logic [2:0]  nbytes;  // 0 = no frame, only check
        logic [3:0]  idx;     // register to check
        logic [7:0]  exp;     // expected value
        logic [3:0]  req;     // requirement number for the message
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{40'h2003A50000, 3'd3, 4'd3,  8'hA5, 4'd4}, // R4 basic write
        '{40'h2083112233, 3'd5, 4'd5,  8'h33, 4'd5}, // R5 sequential
        '{40'h0,          3'd0, 4'd4,  8'h22, 4'd5}, // R5
        '{40'h0,          3'd0, 4'd3,  8'h11, 4'd5}, // R5
        '{40'h2007445566, 3'd5, 4'd7,  8'h66, 4'd5}, // R5 fixed pointer
        '{40'h0,          3'd0, 4'd8,  8'h00, 4'd5}, // R5 neighbour untouched
        '{40'h2202770000, 3'd3, 4'd2,  8'h00, 4'd2}, // R2 wrong identifier
        '{40'h2102770000, 3'd3, 4'd2,  8'h00, 4'd3}, // R3 read flag
        '{40'h208F99AB00, 3'd4, 4'd15, 8'h99, 4'd8}, // R8 run past end
        '{40'h0,          3'd0, 4'd0,  8'h00, 4'd8}, // R8 no wrap
        '{40'h2010EE0000, 3'd3, 4'd0,  8'h00, 4'd8}, // R8 pointer 16
        '{40'h2009C30000, 3'd3, 4'd9,  8'hC3, 4'd1}, // R1 bit order
        '{40'h200A010000, 3'd3, 4'd10, 8'h01, 4'd1}  // R1 bit order
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n_in = 1'b1;
    logic sclk_in = 1'b0;
    logic sdi_in = 1'b0;
    logic [NREG*8-1:0] reg_q;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spi_wr_regport u0 (
        .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in),
        .sclk_in(sclk_in), .sdi_in(sdi_in), .reg_q(reg_q)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send nb whole bytes then extra loose bits, then raise select.
    task automatic send(input logic [39:0] b, input int nb, input int extra);
        int total = nb * 8 + extra;
        cs_n_in = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < total; i++) begin
            sdi_in  = b[39 - i];
            wait_clk(HALF);
            sclk_in = 1'b1;
            wait_clk(HALF);
            sclk_in = 1'b0;
        end
        wait_clk(HALF);
        cs_n_in = 1'b1;
        wait_clk(10);
    endtask

    task automatic chk(input int idx, input logic [7:0] exp, input string req);
        logic [7:0] got = reg_q[idx*8 +: 8];
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s reg%0d actual %02h expected %02h", req, idx, got, exp);
        end
    endtask

    task automatic chk_all_zero(input string req);
        for (int i = 0; i < NREG; i++) chk(i, 8'h00, req);
    endtask

    initial begin
        wait_clk(5);
        chk_all_zero("R7 held in reset");
        rst_n = 1'b1;
        wait_clk(5);
        chk_all_zero("R7 after reset");

        for (int v = 0; v < NVEC; v++) begin
            if (VECS[v].nbytes != 0) send(VECS[v].bytes, int'(VECS[v].nbytes), 0);
            chk(int'(VECS[v].idx), VECS[v].exp, $sformatf("R%0d vec%0d", VECS[v].req, v));
        end

        // R6: select raised after four bits of a data byte
        send(40'h2001F00000, 2, 4);
        chk(1, 8'h00, "R6 partial byte dropped");
        // R6: aborted inside the header, then a clean frame
        send(40'h2000000000, 0, 5);
        send(40'h20015A0000, 3, 0);
        chk(1, 8'h5A, "R6 fresh frame after abort");
        // R6: abort right after the pointer byte leaves data untouched
        send(40'h2006000000, 2, 0);
        chk(6, 8'h00, "R6 no data byte");
        // R7: earlier values retained
        chk(7, 8'h66, "R7 retain");
        chk(15, 8'h99, "R7 retain");
        // R5: increment flag from a previous frame does not leak
        send(40'h200B770000, 3, 0);
        send(40'h200B880000, 3, 0);
        chk(11, 8'h88, "R5 fixed overwrite");
        chk(12, 8'h00, "R5 no advance");
        // R7: reset clears the bank
        rst_n = 1'b0;
        wait_clk(3);
        chk_all_zero("R7 reset clears");
        rst_n = 1'b1;
        wait_clk(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule